// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block stores incoming Ethernet frames in memory through a ring of two-word buffer descriptors. A byte stream marked with start and end flags feeds it. For each buffer it needs, the block reads the first word of the current descriptor. If software still owns that descriptor, the rest of the frame is thrown away and an overrun flag is raised. Otherwise the block fills the buffer the descriptor points at, writes a status word, and hands the descriptor back to software by setting its ownership bit.

Each buffer holds a fixed number of bytes (128 by default), so a long frame spreads over several consecutive descriptors. Start and end markers in each status word let software put the frame back together. The status word of the last buffer also carries the frame length and the destination class. A sticky completion flag tells software that a whole frame is in memory.

The memory port is a simple word port. A read returns its data in the cycle after the request, and a write completes in the cycle it is issued. The ring base is loaded through a queue-pointer write, which also resets the ring position.

Top module: `rxdr_ring_writer`

## Requirements
- R1: After reset the block makes no memory request. `done_o` and `ovr_o` are 0, and `rx_ready_o` is 0 while `rx_valid_i` is 0.
- R2: For each buffer the block reads word 0 of the current descriptor. If bit 0 is clear, the buffer address is word 0 with bits 1:0 forced to zero. After filling the buffer, the block writes the status word to descriptor+4 and then writes word 0 back with bit 0 set, keeping the address and bit 1.
- R3: Frame bytes are stored little-endian, four to a 32-bit word, at consecutive word addresses from the buffer start. In a final partial word the unused upper bytes are zero.
- R4: A buffer holds 128 bytes, and a longer frame continues in the next descriptor. A frame of exactly 128 bytes uses one descriptor.
- R5: Status bit 14 is set only in the first buffer of a frame, and bit 15 only in the last. Bits 11:0 hold the total frame length in the last buffer and are zero in all others.
- R6: In the last buffer exactly one of three status bits is set:
  - bit 31 (broadcast) when the first six bytes are all 0xFF;
  - otherwise bit 30 (multicast) when bit 0 of the first byte is 1;
  - otherwise bit 29 (unicast).
  These bits are zero in all other buffers.
- R7: After a descriptor whose word 0 has bit 1 set, the next descriptor is the ring base. Otherwise the next descriptor is 8 bytes further on.
- R8: A queue-pointer write (`qp_we_i`) loads the ring base and makes the base the next descriptor.
- R9: `done_o` is set after the last descriptor of a complete frame is handed back. Writing 1 to `stat_clr_i[0]` clears it, and a set in the same cycle wins over the clear.
- R10: When a fetched descriptor is still owned (bit 0 = 1), at frame start or mid-frame:
  - nothing is written to that descriptor;
  - the rest of the frame is accepted and discarded;
  - `ovr_o` is set and `done_o` is not;
  - the ring stays on that descriptor.
  Writing 1 to `stat_clr_i[1]` clears `ovr_o`.
- R11: Bytes that arrive while the block is idle without the start marker are accepted and discarded, with no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| qp_we_i | input | 1 | Queue-pointer write strobe |
| qp_base_i | input | AW | Ring base address (8-byte aligned) |
| stat_clr_i | input | 2 | Write-one-to-clear: bit 0 completion, bit 1 overrun |
| rx_valid_i | input | 1 | Frame byte valid |
| rx_data_i | input | 8 | Frame byte |
| rx_sof_i | input | 1 | Byte is the first of a frame |
| rx_eof_i | input | 1 | Byte is the last of a frame |
| rx_ready_o | output | 1 | Byte accepted this cycle when valid |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Byte address of the word |
| mem_wdata_o | output | AW | Write data |
| mem_rdata_i | input | AW | Read data, valid the cycle after a read request |
| done_o | output | 1 | Sticky frame-stored flag |
| ovr_o | output | 1 | Sticky overrun flag |

## Verification
The hardest case to reach is an overrun in the middle of a frame. The ring must have free descriptors for the first buffers and an owned one after them. The bench sets this up by returning only some of the descriptors to the block, then sending a frame long enough to run past the free ones. The bench's memory model tracks ownership per descriptor, so it predicts the exact set of writes before the drop and the ring position that sticks afterwards. A second case rewrites the queue pointer while the ring sits mid-way, so that the next frame must land at the base.

// File: rtl/rxdr_pkg.sv
package rxdr_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_RDW, S_FILL, S_WR, S_STAT, S_OWN, S_DROP
  } rxdr_state_e;

  localparam int unsigned DW_OWN  = 0;
  localparam int unsigned DW_WRAP = 1;
  localparam int unsigned ST_SOF  = 14;
  localparam int unsigned ST_EOF  = 15;
  localparam int unsigned ST_UC   = 29;
  localparam int unsigned ST_MC   = 30;
  localparam int unsigned ST_BC   = 31;
endpackage

// File: rtl/rxdr_ptr.sv
module rxdr_ptr #(
  parameter int unsigned AW = 32,
  parameter int unsigned DESC_BYTES = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic          adv_i,
  input  logic          wrap_i,
  output logic [AW-1:0] desc_o
);
  localparam int unsigned ALN = $clog2(DESC_BYTES);

  logic [AW-1:0] base_q, cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cur_q  <= '0;
    end else if (load_i) begin
      base_q <= {base_i[AW-1:ALN], ALN'(0)};
      cur_q  <= {base_i[AW-1:ALN], ALN'(0)};
    end else if (adv_i) begin
      cur_q <= wrap_i ? base_q : cur_q + AW'(DESC_BYTES);
    end
  end

  assign desc_o = cur_q;
endmodule

// File: rtl/rxdr_packer.sv
module rxdr_packer #(
  parameter int unsigned WB = 4,
  localparam int unsigned LANE_W = $clog2(WB)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [7:0]        byte_i,
  output logic [WB*8-1:0]   word_o
);
  for (genvar l = 0; l < WB; l++) begin : g_lane
    logic [7:0] b_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) b_q <= '0;
      else if (push_i) begin
        if (lane_i == LANE_W'(l)) b_q <= byte_i;
        else if (lane_i == '0)    b_q <= '0;  // new word: clear upper lanes
      end
    end
    assign word_o[l*8 +: 8] = b_q;
  end
endmodule

// File: rtl/rxdr_classifier.sv
module rxdr_classifier #(
  parameter int unsigned ADDR_BYTES = 6,
  localparam int unsigned CW = $clog2(ADDR_BYTES + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       push_i,
  input  logic [7:0] byte_i,
  output logic       bc_o,
  output logic       mc_o,
  output logic       uc_o
);
  logic [CW-1:0] cnt_q;
  logic          ff_q, grp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ff_q  <= 1'b1;
      grp_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= '0;
      ff_q  <= 1'b1;
      grp_q <= 1'b0;
    end else if (push_i && cnt_q < CW'(ADDR_BYTES)) begin
      cnt_q <= cnt_q + 1'b1;
      ff_q  <= ff_q & (byte_i == 8'hFF);
      if (cnt_q == '0) grp_q <= byte_i[0];
    end
  end

  assign bc_o = ff_q && (cnt_q == CW'(ADDR_BYTES));
  assign mc_o = grp_q && !bc_o;
  assign uc_o = !grp_q;
endmodule

// File: rtl/rxdr_ring_writer.sv
module rxdr_ring_writer
  import rxdr_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned BUF_BYTES = 128,
  parameter int unsigned LEN_W = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          qp_we_i,
  input  logic [AW-1:0] qp_base_i,
  input  logic [1:0]    stat_clr_i,
  input  logic          rx_valid_i,
  input  logic [7:0]    rx_data_i,
  input  logic          rx_sof_i,
  input  logic          rx_eof_i,
  output logic          rx_ready_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [AW-1:0] mem_wdata_o,
  input  logic [AW-1:0] mem_rdata_i,
  output logic          done_o,
  output logic          ovr_o
);
  localparam int unsigned WB     = AW / 8;
  localparam int unsigned LANE_W = $clog2(WB);
  localparam int unsigned CNT_W  = $clog2(BUF_BYTES) + 1;

  rxdr_state_e   state_q, state_d;
  logic [AW-1:0] buf_q, desc_addr, word, cls_status;
  logic          wrap_q, first_q, eof_q, done_q, ovr_q;
  logic [CNT_W-1:0] cnt_q, cnt_m1, woff;
  logic [LEN_W-1:0] len_q;
  logic          accept, fill_push, start, owned, done_set, ovr_set;
  logic          bc, mc, uc;

  assign accept    = rx_valid_i && rx_ready_o;
  assign fill_push = (state_q == S_FILL) && accept;
  assign start     = (state_q == S_IDLE) && rx_valid_i && rx_sof_i;
  assign owned     = mem_rdata_i[DW_OWN];
  assign done_set  = (state_q == S_OWN) && eof_q;
  assign ovr_set   = (state_q == S_RDW) && owned;

  rxdr_ptr #(.AW(AW), .DESC_BYTES(8)) u_ptr (
    .clk_i, .rst_ni,
    .load_i (qp_we_i),
    .base_i (qp_base_i),
    .adv_i  (state_q == S_OWN),
    .wrap_i (wrap_q),
    .desc_o (desc_addr)
  );

  rxdr_packer #(.WB(WB)) u_pack (
    .clk_i, .rst_ni,
    .push_i (fill_push),
    .lane_i (cnt_q[LANE_W-1:0]),
    .byte_i (rx_data_i),
    .word_o (word)
  );

  rxdr_classifier #(.ADDR_BYTES(6)) u_cls (
    .clk_i, .rst_ni,
    .start_i (start),
    .push_i  (fill_push),
    .byte_i  (rx_data_i),
    .bc_o    (bc),
    .mc_o    (mc),
    .uc_o    (uc)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (start) state_d = S_RD;
      S_RD:   state_d = S_RDW;
      S_RDW:  state_d = owned ? S_DROP : S_FILL;
      S_FILL: if (accept && (rx_eof_i || cnt_q[LANE_W-1:0] == LANE_W'(WB - 1)))
                state_d = S_WR;
      S_WR:   state_d = (eof_q || cnt_q == CNT_W'(BUF_BYTES)) ? S_STAT : S_FILL;
      S_STAT: state_d = S_OWN;
      S_OWN:  state_d = eof_q ? S_IDLE : S_RD;
      S_DROP: if (accept && rx_eof_i) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_q)
      S_IDLE:         rx_ready_o = rx_valid_i && !rx_sof_i;
      S_FILL, S_DROP: rx_ready_o = 1'b1;
      default:        rx_ready_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      buf_q   <= '0;
      wrap_q  <= 1'b0;
      cnt_q   <= '0;
      len_q   <= '0;
      first_q <= 1'b0;
      eof_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start) begin
        first_q <= 1'b1;
        eof_q   <= 1'b0;
        len_q   <= '0;
      end
      if (state_q == S_RDW && !owned) begin
        buf_q  <= {mem_rdata_i[AW-1:2], 2'b00};
        wrap_q <= mem_rdata_i[DW_WRAP];
        cnt_q  <= '0;
      end
      if (fill_push) begin
        cnt_q <= cnt_q + 1'b1;
        len_q <= len_q + 1'b1;
        eof_q <= rx_eof_i;
      end
      if (state_q == S_OWN) first_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      done_q <= (done_q && !stat_clr_i[0]) || done_set;
      ovr_q  <= (ovr_q && !stat_clr_i[1]) || ovr_set;
    end
  end

  assign cnt_m1 = cnt_q - 1'b1;
  assign woff   = {cnt_m1[CNT_W-1:LANE_W], LANE_W'(0)};

  always_comb begin
    cls_status = '0;
    cls_status[ST_SOF] = first_q;
    if (eof_q) begin
      cls_status[ST_EOF]  = 1'b1;
      cls_status[LEN_W-1:0] = len_q;
      cls_status[ST_BC]   = bc;
      cls_status[ST_MC]   = mc;
      cls_status[ST_UC]   = uc;
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = desc_addr;
    mem_wdata_o = '0;
    unique case (state_q)
      S_RD: mem_req_o = 1'b1;
      S_WR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = buf_q + AW'(woff);
        mem_wdata_o = word;
      end
      S_STAT: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = desc_addr + AW'(4);
        mem_wdata_o = cls_status;
      end
      S_OWN: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_wdata_o = {buf_q[AW-1:2], wrap_q, 1'b1};
      end
      default: ;
    endcase
  end

  assign done_o = done_q;
  assign ovr_o  = ovr_q;
endmodule

// File: rtl/rxdr_ring_writer_chk.sv
module rxdr_ring_writer_chk
  import rxdr_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    stat_clr_i,
  input logic          rx_ready_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_wdata_o,
  input logic [AW-1:0] mem_rdata_i,
  input logic          done_o,
  input logic          ovr_o,
  input rxdr_state_e   state_q
);
  AST_OVR_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RDW && mem_rdata_i[0]) |=> (!mem_req_o && ovr_o)); // R10

  AST_DONE_AFTER_HANDBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(mem_req_o && mem_we_o && mem_wdata_o[0])); // R9

  AST_DONE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_clr_i[0] && state_q != S_OWN) |=> !done_o); // R9

  AST_OVR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_clr_i[1] && state_q != S_RDW) |=> !ovr_o); // R10

  AST_ONE_CLASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && state_q == S_STAT && mem_wdata_o[15])
      |-> $countones(mem_wdata_o[31:29]) == 1); // R6

  AST_READY_NO_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ready_o |-> !mem_req_o); // R11
endmodule

bind rxdr_ring_writer rxdr_ring_writer_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .stat_clr_i  (stat_clr_i),
  .rx_ready_o  (rx_ready_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_rdata_i (mem_rdata_i),
  .done_o      (done_o),
  .ovr_o       (ovr_o),
  .state_q     (state_q)
);

// File: tb/rxdr_ring_writer_tb_top.sv
module rxdr_ring_writer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NDESC = 4;
  localparam logic [31:0] RING = 32'h100;
  localparam logic [31:0] BUF0 = 32'h400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic qp_we = 1'b0; logic [31:0] qp_base = '0;
  logic [1:0] stat_clr = '0;
  logic rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0; logic [7:0] rx_data = '0;
  logic rx_ready_o, mem_req_o, mem_we_o, done_o, ovr_o;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata;
  logic sw_we = 1'b0; logic [31:0] sw_addr = '0, sw_data = '0;

  logic [31:0] mem [1024];
  logic [7:0]  frm [$];
  logic [31:0] exp_addr [$], exp_data [$];
  string       exp_tag [$];
  bit owned [NDESC];
  int idx = 0;
  bit exp_done = 0, exp_ovr = 0;
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit ended = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxdr_ring_writer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .qp_we_i(qp_we), .qp_base_i(qp_base),
    .stat_clr_i(stat_clr), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_sof_i(rx_sof), .rx_eof_i(rx_eof), .rx_ready_o(rx_ready_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata),
    .done_o(done_o), .ovr_o(ovr_o)
  );

  always @(posedge clk) begin
    if (mem_req_o && !mem_we_o) mem_rdata <= mem[mem_addr_o[11:2]];
    if (mem_req_o && mem_we_o)  mem[mem_addr_o[11:2]] <= mem_wdata_o;
    if (sw_we) mem[sw_addr[11:2]] <= sw_data;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // every write the design makes is compared against the model's queue
  always @(negedge clk) begin
    if (rst_n && mem_req_o && mem_we_o) begin
      if (exp_addr.size() == 0) chk(0, "R2 unexpected write addr", mem_addr_o, 32'hx);
      else begin
        chk(mem_addr_o == exp_addr[0], {exp_tag[0], " addr"}, mem_addr_o, exp_addr[0]);
        chk(mem_wdata_o == exp_data[0], {exp_tag[0], " data"}, mem_wdata_o, exp_data[0]);
        void'(exp_addr.pop_front()); void'(exp_data.pop_front()); void'(exp_tag.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !ended) begin
      ended = 1; n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <50000 cycles", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  function automatic logic [31:0] dsc(input int i); return RING + 32'(i * 8); endfunction
  function automatic logic [31:0] w0(input int i);
    return BUF0 + 32'(i * 128) + ((i == NDESC - 1) ? 32'd2 : 32'd0);
  endfunction

  task automatic push(input logic [31:0] a, input logic [31:0] d, input string t);
    exp_addr.push_back(a); exp_data.push_back(d); exp_tag.push_back(t);
  endtask

  task automatic sw_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); sw_we = 1; sw_addr = a; sw_data = d;
    @(negedge clk); sw_we = 0;
  endtask

  task automatic release_desc(input int i);
    sw_write(dsc(i), w0(i)); owned[i] = 0;
  endtask

  task automatic set_base(input logic [31:0] b);
    @(negedge clk); qp_we = 1; qp_base = b;
    @(negedge clk); qp_we = 0; idx = 0;
  endtask

  task automatic clear(input logic [1:0] m);
    @(negedge clk); stat_clr = m;
    @(negedge clk); stat_clr = 0;
    if (m[0]) exp_done = 0;
    if (m[1]) exp_ovr = 0;
    chk(done_o == exp_done, "R9 clear done", 32'(done_o), 32'(exp_done));
    chk(ovr_o == exp_ovr, "R10 clear overrun", 32'(ovr_o), 32'(exp_ovr));
  endtask

  task automatic build(input int len, input logic [7:0] b0, input bit bcast, input int seed);
    frm.delete();
    for (int k = 0; k < len; k++) frm.push_back(8'((seed + k * 7) & 8'hFF));
    frm[0] = b0;
    if (bcast) for (int k = 0; k < 6 && k < len; k++) frm[k] = 8'hFF;
  endtask

  task automatic model_frame();
    int len = frm.size(); int pos = 0; bit first = 1;
    bit bc, mc, uc;
    logic [31:0] st, word, ba;
    bc = (len >= 6);
    for (int k = 0; k < 6 && k < len; k++) if (frm[k] != 8'hFF) bc = 0;
    mc = !bc && frm[0][0];
    uc = !frm[0][0];
    while (1) begin
      int n; bit last;
      if (owned[idx]) begin exp_ovr = 1; break; end
      n = (len - pos > 128) ? 128 : len - pos;
      ba = BUF0 + 32'(idx * 128);
      for (int w = 0; w < (n + 3) / 4; w++) begin
        word = '0;
        for (int b = 0; b < 4; b++) if (w * 4 + b < n) word[b*8 +: 8] = frm[pos + w * 4 + b];
        push(ba + 32'(w * 4), word, "R3,R4 buffer word");
      end
      last = (pos + n == len);
      st = '0; st[14] = first;
      if (last) begin
        st[15] = 1; st[11:0] = 12'(len); st[31] = bc; st[30] = mc; st[29] = uc;
      end
      push(dsc(idx) + 4, st, "R5,R6 status");
      push(dsc(idx), w0(idx) | 32'd1, "R2,R7 handback");
      owned[idx] = 1;
      idx = (idx == NDESC - 1) ? 0 : idx + 1;
      pos += n; first = 0;
      if (last) begin exp_done = 1; break; end
    end
  endtask

  task automatic drive_frame();
    for (int k = 0; k < frm.size(); k++) begin
      @(negedge clk);
      rx_valid = 1; rx_data = frm[k]; rx_sof = (k == 0); rx_eof = (k == frm.size() - 1);
      #1;
      while (!rx_ready_o) begin @(negedge clk); #1; end
    end
    @(negedge clk); rx_valid = 0; rx_sof = 0; rx_eof = 0;
  endtask

  task automatic run_frame(input string tag);
    model_frame();
    drive_frame();
    repeat (12) @(negedge clk);
    chk(exp_addr.size() == 0, {tag, " all writes seen"}, 32'(exp_addr.size()), 0);
    chk(done_o == exp_done, {tag, " done_o"}, 32'(done_o), 32'(exp_done));
    chk(ovr_o == exp_ovr, {tag, " ovr_o"}, 32'(ovr_o), 32'(exp_ovr));
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    for (int i = 0; i < NDESC; i++) begin
      mem[(dsc(i) >> 2)] = w0(i); mem[(dsc(i) >> 2) + 1] = '0; owned[i] = 0;
    end
    repeat (3) @(negedge clk);
    chk(!mem_req_o && !done_o && !ovr_o && !rx_ready_o, "R1 in reset", {mem_req_o, done_o, ovr_o, rx_ready_o}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!mem_req_o && !done_o && !ovr_o && !rx_ready_o, "R1 after reset", {mem_req_o, done_o, ovr_o, rx_ready_o}, 0);

    set_base(RING);
    build(60, 8'h02, 0, 3);   run_frame("R3 unicast 60");
    clear(2'b01);

    // R11: stray byte while idle
    @(negedge clk); rx_valid = 1; rx_data = 8'h5A; rx_sof = 0; rx_eof = 0; #1;
    chk(rx_ready_o == 1'b1, "R11 stray byte accepted", 32'(rx_ready_o), 1);
    @(negedge clk); rx_valid = 0;
    repeat (4) @(negedge clk);
    chk(exp_addr.size() == 0 && !done_o, "R11 stray byte no effect", 32'(done_o), 0);

    build(200, 8'h00, 1, 11); run_frame("R4 broadcast 200");
    for (int i = 0; i < 3; i++) release_desc(i);
    clear(2'b01);
    build(129, 8'h01, 0, 5);  run_frame("R7 multicast wrap 129");
    clear(2'b01);
    build(300, 8'h04, 0, 9);  run_frame("R10 mid-frame overrun");
    clear(2'b10);
    release_desc(3);
    build(5, 8'hFF, 1, 1);    run_frame("R6 short all-ones");
    clear(2'b01);
    build(40, 8'h06, 0, 2);   run_frame("R10 overrun at start");
    clear(2'b10);
    for (int i = 0; i < 3; i++) release_desc(i);
    build(20, 8'h08, 0, 7);   run_frame("R2 after overrun");
    set_base(RING);
    release_desc(0);
    clear(2'b01);
    build(128, 8'h0A, 0, 13); run_frame("R8 rebase, R4 exact 128");

    if (!ended) begin
      ended = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule